// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block is the control step that moves a processor core into an exception or interrupt handler. Each cycle it looks at a pending exception code and at a hardware interrupt request. The interrupt request comes with a vector, and a vector-valid flag, from an external interrupt controller. The block also looks at the delay-slot and sleep state and at the current PC, SR, VBR and R15 values.

When an entry is accepted, the block does the following at one clock edge:
- It captures the saved status, saved PC and saved stack pointer into shadow registers.
- It records the event code.
- It presents the new SR and the new PC that the core must load.
- It pulses `entry_taken` for one cycle. The core uses this pulse to leave sleep and to drop any load-linked reservation.

When an exception arrives while the block bit of SR is set, the block does not perform an entry. Instead it issues a one-cycle reset request. The core executes instructions, and the interrupt controller and the register file live outside this block.

The entry target depends on the class of the event:
- The reset-class codes use a fixed reset address.
- The two TLB-miss codes use their own offset from VBR.
- Every other exception uses a general offset.
- Interrupts use a separate interrupt offset.

The saved PC is adjusted in two cases. It steps back by 2 when the event hits a delay slot, so that the branch is replayed. It steps forward by 2 for the trap code.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the following outputs are all zero: every registered output, every shadow register, `pc_next`, `sr_next`, `entry_taken`, `reset_req` and `slot_clr`.
- R2: Suppose an exception and an interrupt are both pending in the same cycle. Then the exception is taken: `expevt_q` receives the code, `intevt_q` is unchanged, and the interrupt is not serviced.
- R3: Suppose SR bit 28 (block) is set and an exception with a code other than 0x1E0 is pending. Then `reset_req` pulses in the following cycle. `entry_taken` stays low, and none of the shadow registers, `pc_next` or `sr_next` changes.
- R4: While SR bit 28 is set, an interrupt is ignored unless `in_sleep` is high. While asleep, the interrupt is accepted normally.
- R5: On any entry, `ssr_q` receives SR and `sgr_q` receives R15. `sr_next` equals SR with bits 30, 29 and 28 set, except where R7 also applies.
- R6: If an entry happens while `in_delay_slot` is high, `spc_q` receives PC minus 2 and `slot_clr` pulses together with `entry_taken`. In every other case `spc_q` receives PC, or the value R9 gives.
- R7: For exception codes 0x000, 0x020 and 0x140, `sr_next` also has bit 15 cleared and bits [7:4] set to 0xF. `pc_next` is 0xA0000000.
- R8: For exception codes 0x040 and 0x060, `pc_next` is VBR+0x400. Every other exception that is not covered by R7 gives VBR+0x100. Every exception entry writes its code into `expevt_q`.
- R9: For exception code 0x160 (trap), `spc_q` receives the saved PC plus 2. This is applied after any delay-slot adjustment.
- R10: `irq_level` always equals SR[7:4]. If an interrupt arrives while `irq_vec_valid` is low, nothing happens. Otherwise `intevt_q` receives the vector, `pc_next` is VBR+0x600, and `expevt_q` is unchanged.
- R11: An interrupt request is not accepted while `in_delay_slot` is high.
- R12: `entry_taken` is high for exactly the one cycle after each accepted entry. When there is no entry, the shadow registers, `pc_next` and `sr_next` hold their values.
- R13: With SR bit 28 set, an exception with code 0x1E0 performs a normal entry and raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_pending | input | 1 | An exception is pending this cycle |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | Hardware interrupt request |
| irq_vec_valid | input | 1 | The interrupt controller returned a vector for the current mask level |
| irq_vec | input | 12 | Interrupt vector from the controller |
| in_delay_slot | input | 1 | The current instruction sits in a delay slot |
| in_sleep | input | 1 | The core is sleeping |
| pc | input | 32 | Current program counter |
| sr | input | 32 | Current status register |
| vbr | input | 32 | Vector base |
| r15 | input | 32 | Current stack pointer |
| irq_level | output | 4 | Mask level sent to the interrupt controller |
| entry_taken | output | 1 | One-cycle pulse on an accepted entry; the core also uses it to clear sleep and the reservation |
| reset_req | output | 1 | One-cycle reset request from a blocked exception |
| slot_clr | output | 1 | Clear the delay-slot flag |
| pc_next | output | 32 | PC for the core to load on entry |
| sr_next | output | 32 | SR for the core to load on entry |
| ssr_q | output | 32 | Saved status |
| spc_q | output | 32 | Saved PC |
| sgr_q | output | 32 | Saved R15 |
| expevt_q | output | 12 | Last exception code |
| intevt_q | output | 12 | Last interrupt vector |

## Verification
Two functions can fall in the same cycle: an exception entry and an interrupt request. The block bit adds two more: the blocked-exception reset path and the sleep override, either of which can coincide with a pending interrupt.

The bench sweeps every exception code the block distinguishes. It crosses each code with the block bit and the delay-slot flag, once with an interrupt held pending and once without. It then sweeps every mask level across vector-valid, delay-slot, block and sleep.

The expected action, target, saved PC and event registers are computed arithmetically from the requirements. The bench then compares them at the cycle after the capturing edge. In the cases where nothing may happen, it confirms that the outputs held their values.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception entry sequencer.
// Assumes a 32-bit status register with the mode bits at fixed positions.
package exc_pkg;
    localparam int SR_MD_BIT = 30;
    localparam int SR_RB_BIT = 29;
    localparam int SR_BL_BIT = 28;
    localparam int SR_FD_BIT = 15;
    localparam int SR_IMASK_LO = 4;
    localparam int IMASK_W = 4;

    localparam logic [11:0] CODE_PWR_RESET  = 12'h000;
    localparam logic [11:0] CODE_MAN_RESET  = 12'h020;
    localparam logic [11:0] CODE_TLB_MULTI  = 12'h140;
    localparam logic [11:0] CODE_TLB_MISS_R = 12'h040;
    localparam logic [11:0] CODE_TLB_MISS_W = 12'h060;
    localparam logic [11:0] CODE_TRAP       = 12'h160;
    localparam logic [11:0] CODE_UNBLOCKED  = 12'h1E0;

    localparam logic [31:0] RESET_TARGET = 32'hA000_0000;
    localparam logic [31:0] OFS_TLB      = 32'h0000_0400;
    localparam logic [31:0] OFS_GENERAL  = 32'h0000_0100;
    localparam logic [31:0] OFS_IRQ      = 32'h0000_0600;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_EXC   = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_RESET = 2'd3
    } act_e;
endpackage

// File: rtl/exc_arbiter.sv
// Chooses the action for this cycle: none, exception entry, interrupt entry
// or reset request. Assumes the vector-valid flag already reflects the
// current mask level.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              irq_vec_valid,
    input  logic              in_delay_slot,
    input  logic              in_sleep,
    input  logic              blocked,
    output act_e              act
);
    logic irq_eligible;

    // An interrupt is eligible only without an exception and outside a delay slot.
    always_comb irq_eligible = irq_req && !exc_pending && !in_delay_slot;

    // Priority: blocked exception, exception, unmasked interrupt with a vector.
    always_comb begin
        act = ACT_NONE;
        if (exc_pending) begin
            if (blocked && (exc_code != CODE_W'(CODE_UNBLOCKED)))
                act = ACT_RESET;
            else
                act = ACT_EXC;
        end else if (irq_eligible && (!blocked || in_sleep) && irq_vec_valid) begin
            act = ACT_IRQ;
        end
    end
endmodule

// File: rtl/exc_target.sv
// Computes the new PC, the new SR and the return PC for an entry.
// Assumes the action has already been chosen; results are don't-care for
// ACT_NONE and ACT_RESET.
module exc_target
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  act_e              act,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   vbr,
    input  logic              in_delay_slot,
    output logic [XLEN-1:0]   tgt_pc,
    output logic [XLEN-1:0]   tgt_sr,
    output logic [XLEN-1:0]   ret_pc
);
    logic reset_class;
    logic tlb_class;
    logic is_trap;
    logic [XLEN-1:0] slot_pc;

    // Classify the exception code.
    always_comb begin
        reset_class = (exc_code == CODE_W'(CODE_PWR_RESET)) ||
                      (exc_code == CODE_W'(CODE_MAN_RESET)) ||
                      (exc_code == CODE_W'(CODE_TLB_MULTI));
        tlb_class   = (exc_code == CODE_W'(CODE_TLB_MISS_R)) ||
                      (exc_code == CODE_W'(CODE_TLB_MISS_W));
        is_trap     = (act == ACT_EXC) && (exc_code == CODE_W'(CODE_TRAP));
    end

    // Return PC: step back over a delay slot, then step past a trap.
    always_comb begin
        slot_pc = in_delay_slot ? pc - XLEN'(2) : pc;
        ret_pc  = is_trap ? slot_pc + XLEN'(2) : slot_pc;
    end

    // New SR: raise the mode bits; reset-class codes also reset FD and the mask.
    always_comb begin
        tgt_sr = sr;
        tgt_sr[SR_MD_BIT] = 1'b1;
        tgt_sr[SR_RB_BIT] = 1'b1;
        tgt_sr[SR_BL_BIT] = 1'b1;
        if ((act == ACT_EXC) && reset_class) begin
            tgt_sr[SR_FD_BIT] = 1'b0;
            tgt_sr[SR_IMASK_LO +: IMASK_W] = '1;
        end
    end

    // New PC according to the event class.
    always_comb begin
        if (act == ACT_IRQ)
            tgt_pc = vbr + XLEN'(OFS_IRQ);
        else if (reset_class)
            tgt_pc = XLEN'(RESET_TARGET);
        else if (tlb_class)
            tgt_pc = vbr + XLEN'(OFS_TLB);
        else
            tgt_pc = vbr + XLEN'(OFS_GENERAL);
    end
endmodule

// File: rtl/exc_shadow_regs.sv
// Holds the shadow registers, the event registers and the entry pulses.
// Assumes the action is valid for the cycle in which it is presented.
module exc_shadow_regs
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   r15,
    input  logic [XLEN-1:0]   ret_pc,
    input  logic [XLEN-1:0]   tgt_pc,
    input  logic [XLEN-1:0]   tgt_sr,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] irq_vec,
    input  logic              in_delay_slot,
    output logic              entry_taken,
    output logic              reset_req,
    output logic              slot_clr,
    output logic [XLEN-1:0]   pc_next,
    output logic [XLEN-1:0]   sr_next,
    output logic [XLEN-1:0]   ssr_q,
    output logic [XLEN-1:0]   spc_q,
    output logic [XLEN-1:0]   sgr_q,
    output logic [CODE_W-1:0] expevt_q,
    output logic [CODE_W-1:0] intevt_q
);
    logic do_entry;

    // An entry is either kind of accepted event.
    always_comb do_entry = (act == ACT_EXC) || (act == ACT_IRQ);

    // One-cycle pulses for entry, reset request and delay-slot clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_taken <= 1'b0;
            reset_req   <= 1'b0;
            slot_clr    <= 1'b0;
        end else begin
            entry_taken <= do_entry;
            reset_req   <= (act == ACT_RESET);
            slot_clr    <= do_entry && in_delay_slot;
        end
    end

    // Save state and load the targets on an entry; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_next <= '0;
            sr_next <= '0;
            ssr_q   <= '0;
            spc_q   <= '0;
            sgr_q   <= '0;
        end else if (do_entry) begin
            pc_next <= tgt_pc;
            sr_next <= tgt_sr;
            ssr_q   <= sr;
            spc_q   <= ret_pc;
            sgr_q   <= r15;
        end
    end

    // Event registers: exception code or interrupt vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expevt_q <= '0;
            intevt_q <= '0;
        end else if (act == ACT_EXC) begin
            expevt_q <= exc_code;
        end else if (act == ACT_IRQ) begin
            intevt_q <= irq_vec;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Top of the exception and interrupt entry sequencer. It arbitrates the
// events, computes the targets and captures the shadow state in one clock.
// Assumes the core loads pc_next and sr_next while entry_taken is high.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              irq_vec_valid,
    input  logic [CODE_W-1:0] irq_vec,
    input  logic              in_delay_slot,
    input  logic              in_sleep,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   vbr,
    input  logic [XLEN-1:0]   r15,
    output logic [IMASK_W-1:0] irq_level,
    output logic              entry_taken,
    output logic              reset_req,
    output logic              slot_clr,
    output logic [XLEN-1:0]   pc_next,
    output logic [XLEN-1:0]   sr_next,
    output logic [XLEN-1:0]   ssr_q,
    output logic [XLEN-1:0]   spc_q,
    output logic [XLEN-1:0]   sgr_q,
    output logic [CODE_W-1:0] expevt_q,
    output logic [CODE_W-1:0] intevt_q
);
    act_e act;
    logic [XLEN-1:0] tgt_pc;
    logic [XLEN-1:0] tgt_sr;
    logic [XLEN-1:0] ret_pc;

    // Mask level presented to the interrupt controller.
    always_comb irq_level = sr[SR_IMASK_LO +: IMASK_W];

    exc_arbiter #(.CODE_W(CODE_W)) u_arb (
        .exc_pending   (exc_pending),
        .exc_code      (exc_code),
        .irq_req       (irq_req),
        .irq_vec_valid (irq_vec_valid),
        .in_delay_slot (in_delay_slot),
        .in_sleep      (in_sleep),
        .blocked       (sr[SR_BL_BIT]),
        .act           (act)
    );

    exc_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tgt (
        .act           (act),
        .exc_code      (exc_code),
        .pc            (pc),
        .sr            (sr),
        .vbr           (vbr),
        .in_delay_slot (in_delay_slot),
        .tgt_pc        (tgt_pc),
        .tgt_sr        (tgt_sr),
        .ret_pc        (ret_pc)
    );

    exc_shadow_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .act           (act),
        .sr            (sr),
        .r15           (r15),
        .ret_pc        (ret_pc),
        .tgt_pc        (tgt_pc),
        .tgt_sr        (tgt_sr),
        .exc_code      (exc_code),
        .irq_vec       (irq_vec),
        .in_delay_slot (in_delay_slot),
        .entry_taken   (entry_taken),
        .reset_req     (reset_req),
        .slot_clr      (slot_clr),
        .pc_next       (pc_next),
        .sr_next       (sr_next),
        .ssr_q         (ssr_q),
        .spc_q         (spc_q),
        .sgr_q         (sgr_q),
        .expevt_q      (expevt_q),
        .intevt_q      (intevt_q)
    );
endmodule

// File: rtl/exc_entry_seq_chk.sv
// Property checker for the entry sequencer, bound to the top module.
// Assumes the port names of exc_entry_seq.
module exc_entry_seq_chk
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_pending,
    input logic              irq_req,
    input logic [XLEN-1:0]   sr,
    input logic              entry_taken,
    input logic              reset_req,
    input logic              slot_clr,
    input logic [XLEN-1:0]   pc_next,
    input logic [XLEN-1:0]   sr_next,
    input logic [XLEN-1:0]   ssr_q,
    input logic [XLEN-1:0]   spc_q,
    input logic [XLEN-1:0]   sgr_q,
    input logic [CODE_W-1:0] expevt_q,
    input logic [CODE_W-1:0] intevt_q
);
    // R3
    reset_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !entry_taken);

    // R3
    reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> ($past(exc_pending) && $past(sr[SR_BL_BIT])));

    // R3
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> ($stable(ssr_q) && $stable(spc_q) && $stable(pc_next) && $stable(expevt_q)));

    // R5
    mode_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_taken |-> (sr_next[SR_MD_BIT] && sr_next[SR_RB_BIT] && sr_next[SR_BL_BIT]));

    // R6
    slot_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_clr |-> entry_taken);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_taken |-> ($stable(spc_q) && $stable(ssr_q) && $stable(sgr_q) &&
                          $stable(pc_next) && $stable(sr_next)));

    // R10
    event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_taken |-> ($stable(expevt_q) && $stable(intevt_q)));

    // R2
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_taken && $past(exc_pending) && $past(irq_req)) |-> $stable(intevt_q));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_pending (exc_pending),
    .irq_req     (irq_req),
    .sr          (sr),
    .entry_taken (entry_taken),
    .reset_req   (reset_req),
    .slot_clr    (slot_clr),
    .pc_next     (pc_next),
    .sr_next     (sr_next),
    .ssr_q       (ssr_q),
    .spc_q       (spc_q),
    .sgr_q       (sgr_q),
    .expevt_q    (expevt_q),
    .intevt_q    (intevt_q)
);

// File: tb/tb_exc_entry_seq.sv
// Sweeping bench for the entry sequencer; expected values from the requirements.
module tb_exc_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int CODE_W = 12;
    localparam logic [31:0] VBR_VAL = 32'h8C00_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_pending = 1'b0;
    logic [CODE_W-1:0] exc_code = '0;
    logic irq_req = 1'b0;
    logic irq_vec_valid = 1'b0;
    logic [CODE_W-1:0] irq_vec = '0;
    logic in_delay_slot = 1'b0;
    logic in_sleep = 1'b0;
    logic [XLEN-1:0] pc = '0;
    logic [XLEN-1:0] sr = '0;
    logic [XLEN-1:0] vbr = VBR_VAL;
    logic [XLEN-1:0] r15 = '0;
    logic [3:0] irq_level;
    logic entry_taken, reset_req, slot_clr;
    logic [XLEN-1:0] pc_next, sr_next, ssr_q, spc_q, sgr_q;
    logic [CODE_W-1:0] expevt_q, intevt_q;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_pc, m_sr, m_ssr, m_spc, m_sgr;
    logic [11:0] m_exp, m_int;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .exc_pending(exc_pending), .exc_code(exc_code),
        .irq_req(irq_req), .irq_vec_valid(irq_vec_valid), .irq_vec(irq_vec),
        .in_delay_slot(in_delay_slot), .in_sleep(in_sleep), .pc(pc), .sr(sr),
        .vbr(vbr), .r15(r15), .irq_level(irq_level), .entry_taken(entry_taken),
        .reset_req(reset_req), .slot_clr(slot_clr), .pc_next(pc_next),
        .sr_next(sr_next), .ssr_q(ssr_q), .spc_q(spc_q), .sgr_q(sgr_q),
        .expevt_q(expevt_q), .intevt_q(intevt_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit e, input logic [11:0] code, input bit ir,
                        input bit vv, input logic [11:0] vec, input bit ds,
                        input bit slp, input logic [31:0] p, input logic [31:0] s,
                        input logic [31:0] sp);
        bit bl, x_entry, x_rst, x_slot, rst_cls;
        string tag;
        logic [31:0] ns;
        @(negedge clk);
        exc_pending = e; exc_code = code; irq_req = ir; irq_vec_valid = vv;
        irq_vec = vec; in_delay_slot = ds; in_sleep = slp; pc = p; sr = s; r15 = sp;
        #1;
        chk("R10", "irq_level", 32'(irq_level), 32'(s[7:4]));
        bl = s[28]; x_entry = 0; x_rst = 0; x_slot = 0; tag = "R12";
        ns = s | 32'h7000_0000;
        if (e && bl && code != 12'h1E0) begin
            x_rst = 1; tag = "R3";
        end else if (e) begin
            x_entry = 1; x_slot = ds;
            tag = (bl ? "R13" : (ir ? "R2" : "R8"));
            m_ssr = s; m_sgr = sp; m_exp = code;
            m_spc = p - (ds ? 32'd2 : 32'd0) + (code == 12'h160 ? 32'd2 : 32'd0);
            rst_cls = (code == 12'h000) || (code == 12'h020) || (code == 12'h140);
            if (rst_cls) begin
                ns[15] = 1'b0; ns[7:4] = 4'hF; m_pc = 32'hA000_0000; tag = "R7";
            end else if (code == 12'h040 || code == 12'h060) begin
                m_pc = VBR_VAL + 32'h400;
            end else begin
                m_pc = VBR_VAL + 32'h100;
            end
            if (code == 12'h160) tag = "R9";
            m_sr = ns;
        end else if (ir && !ds && (!bl || slp) && vv) begin
            x_entry = 1; tag = (bl ? "R4" : "R10");
            m_ssr = s; m_sgr = sp; m_spc = p; m_int = vec;
            m_pc = VBR_VAL + 32'h600; m_sr = ns;
        end else if (ir && ds) begin
            tag = "R11";
        end else if (ir && bl) begin
            tag = "R4";
        end
        @(posedge clk);
        #1;
        chk(tag, "entry_taken", 32'(entry_taken), 32'(x_entry));
        chk(tag, "reset_req", 32'(reset_req), 32'(x_rst));
        chk("R6", "slot_clr", 32'(slot_clr), 32'(x_slot));
        chk(tag, "pc_next", pc_next, m_pc);
        chk("R5", "sr_next", sr_next, m_sr);
        chk("R5", "ssr", ssr_q, m_ssr);
        chk(ds ? "R6" : tag, "spc", spc_q, m_spc);
        chk("R5", "sgr", sgr_q, m_sgr);
        chk(tag, "expevt", 32'(expevt_q), 32'(m_exp));
        chk(tag, "intevt", 32'(intevt_q), 32'(m_int));
    endtask

    task automatic idle();
        step(0, 12'h000, 0, 0, 12'h000, 0, 0, 32'h0, 32'h0, 32'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        m_pc = '0; m_sr = '0; m_ssr = '0; m_spc = '0; m_sgr = '0; m_exp = '0; m_int = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "entry_taken", 32'(entry_taken), 32'd0);
        chk("R1", "reset_req", 32'(reset_req), 32'd0);
        chk("R1", "slot_clr", 32'(slot_clr), 32'd0);
        chk("R1", "pc_next", pc_next, 32'd0);
        chk("R1", "sr_next", sr_next, 32'd0);
        chk("R1", "ssr", ssr_q, 32'd0);
        chk("R1", "spc", spc_q, 32'd0);
        chk("R1", "expevt", 32'(expevt_q), 32'd0);
        chk("R1", "intevt", 32'(intevt_q), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // Exception sweep: codes 0x000..0x1E0 plus two high codes, x block, slot, irq.
        for (int c = 0; c < 18; c++) begin
            for (int k = 0; k < 8; k++) begin
                logic [11:0] code;
                logic [31:0] s;
                code = (c < 16) ? 12'(c * 32) : ((c == 16) ? 12'h800 : 12'h820);
                s = 32'h0000_8051 | (32'(k[0]) << 28) | (32'(c[3:0]) << 8);
                step(1, code, k[2], 1, 12'h3A0 + 12'(k), k[1],
                     0, 32'h0C00_1000 + 32'(c * 64 + k * 4), s, 32'h0BFF_0000 + 32'(c));
                idle();
            end
        end
        // Interrupt sweep: mask level x vector valid x slot x block x sleep.
        for (int lv = 0; lv < 16; lv++) begin
            for (int k = 0; k < 16; k++) begin
                logic [31:0] s;
                s = 32'h0000_0002 | (32'(lv) << 4) | (32'(k[2]) << 28);
                step(0, 12'h000, 1, k[0], 12'h200 + 12'(lv * 32 + k), k[1],
                     k[3], 32'h0C10_0000 + 32'(lv * 256 + k * 2), s, 32'h0C20_0000 + 32'(k));
                idle();
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule